// File: doc/BRIEF.md
# Two-Slice 8-Bit Arithmetic/Logic Unit with Flags

This block is the arithmetic core of a small processor data path. It holds an 8-bit accumulator and works on it together with a data-storage operand (`d_in`). The operation is chosen by a 4-bit code. The datapath is built from two identical 4-bit slices joined by a carry chain. The low slice always sees a carry-in of zero and never reports overflow. The high slice takes the low slice's carry out, and only the high slice produces the overflow condition. The operands are combined combinationally while the clock is high. The result, together with the carry, zero, negative and overflow flags, is captured on the falling clock edge.

An operation is offered by raising `alu_valid` with `alu_op` and `d_in` set up before a falling edge. The block never stalls, so it has no ready output: every valid operation is accepted at the next falling edge, and there is no back-pressure to honour. The flags register is always visible on `flags_out` in bus format, with carry in bit 0. Pulsing `flag_clr` (the write strobe for the flags address) clears the flags register. Single-bit shifts report the bit they shift out as the carry, so wider words can be shifted one byte at a time. Rotations leave the flags untouched.

Top module: `duo_alu`

## Requirements
- R1: While `rst_n` is low, `acc_out` reads 0x00 and `flags_out` reads 0x00.
- R2: Code 0 (add) stores acc+d and code 1 (count-up) stores acc+1, ignoring `d_in`. For both, carry (`flags_out` bit 0) is the carry out of the 8-bit sum, and overflow (bit 3) is set when the two addends share a sign bit and the result's sign differs.
- R3: The carry out of bits 3..0 feeds bits 7..4, so 0x0F+0x01 gives 0x10 with carry 0. Overflow comes from the top slice only: 0x08+0x08 gives overflow 0, and 0x7F+0x01 gives overflow 1.
- R4: Subtraction adds a two's-complemented operand with no extra carry-in. Code 2 computes acc+(−d), code 3 computes d+(−acc), code 4 computes 0+(−acc), and code 5 computes acc+0xFF. Carry and overflow follow the rule of R2, applied to the two addends used.
- R5: Codes 6 (AND with d), 7 (OR), 8 (XOR), 9 (invert acc) and 12 (load d) store their result with carry 0 and overflow 0.
- R6: Code 10 shifts acc left by one, filling with 0, and sets carry to the old bit 7. Code 11 shifts right by one, filling with 0, and sets carry to the old bit 0. Overflow is 0 for both.
- R7: Code 13 rotates acc left by one and code 14 rotates it right by one. Both leave all four flags unchanged.
- R8: For every operation other than codes 13 to 15, zero (bit 1) is set exactly when both nibbles of the result are zero, and negative (bit 2) equals result bit 7.
- R9: `flags_out` bits 7..4 always read 0. A cycle with `flag_clr` high clears all flags at that falling edge, even when an operation is accepted in the same cycle.
- R10: With `alu_valid` low, or with code 15, neither the accumulator nor the flags change (apart from a clear requested by R9).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_valid | input | 1 | Operation offered this cycle |
| alu_op | input | 4 | Operation code |
| d_in | input | 8 | Data-storage operand |
| flag_clr | input | 1 | Write strobe to the flags address; clears the flags |
| acc_out | output | 8 | Accumulator value |
| flags_out | output | 8 | Flags in bus format: {0000, overflow, negative, zero, carry} |

## Verification
Every result of this block, both the new accumulator value and the new flags, is due at the first falling edge after the operation is presented. The bench drives the inputs 1 ns after a rising edge and samples both outputs 1 ns after the following falling edge, before it changes any input again. A clear and a no-effect cycle take the same single falling edge to show at the ports. The bench checks them at that same point, so each expected value is compared exactly one capture after its stimulus.

// File: rtl/duo_alu_pkg.sv
`timescale 1ns/1ps
package duo_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_INC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SM   = 4'd3,
    OP_SMZ  = 4'd4,
    OP_DEC  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_NOT  = 4'd9,
    OP_SHL  = 4'd10,
    OP_SHR  = 4'd11,
    OP_LOAD = 4'd12,
    OP_ROL  = 4'd13,
    OP_ROR  = 4'd14,
    OP_RSVD = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    F_SUM, F_AND, F_OR, F_XOR, F_NOTA, F_PASSB, F_SHL, F_SHR
  } slice_fn_e;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/duo_alu_decode.sv
`timescale 1ns/1ps
module duo_alu_decode
  import duo_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] d,
  output logic [W-1:0] opa,
  output logic [W-1:0] opb,
  output slice_fn_e    fn,
  output logic         lsb_in,
  output logic         msb_in,
  output logic         wr_acc,
  output logic         upd_flags
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic [W-1:0] neg_d;
  logic [W-1:0] neg_acc;

  assign neg_d   = ~d + ONE;
  assign neg_acc = ~acc + ONE;

  always_comb begin
    opa       = acc;
    opb       = d;
    fn        = F_SUM;
    lsb_in    = 1'b0;
    msb_in    = 1'b0;
    wr_acc    = 1'b1;
    upd_flags = 1'b1;
    case (alu_op_e'(op))
      OP_ADD:  ;
      OP_INC:  opb = ONE;
      OP_SUB:  opb = neg_d;
      OP_SM: begin
        opa = d;
        opb = neg_acc;
      end
      OP_SMZ: begin
        opa = '0;
        opb = neg_acc;
      end
      OP_DEC:  opb = ONES;
      OP_AND:  fn = F_AND;
      OP_OR:   fn = F_OR;
      OP_XOR:  fn = F_XOR;
      OP_NOT:  fn = F_NOTA;
      OP_SHL:  fn = F_SHL;
      OP_SHR:  fn = F_SHR;
      OP_LOAD: fn = F_PASSB;
      OP_ROL: begin
        fn        = F_SHL;
        lsb_in    = acc[W-1];
        upd_flags = 1'b0;
      end
      OP_ROR: begin
        fn        = F_SHR;
        msb_in    = acc[0];
        upd_flags = 1'b0;
      end
      default: begin
        fn        = F_PASSB;
        wr_acc    = 1'b0;
        upd_flags = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/duo_alu_slice.sv
`timescale 1ns/1ps
module duo_alu_slice
  import duo_alu_pkg::*;
#(
  parameter int SW     = 4,
  parameter bit IS_MSB = 1'b0
) (
  input  slice_fn_e     fn,
  input  logic [SW-1:0] a,
  input  logic [SW-1:0] b,
  input  logic          cin,
  input  logic          sl_in,
  input  logic          sr_in,
  output logic [SW-1:0] r,
  output logic          cout,
  output logic          zero,
  output logic          ovf,
  output logic          sl_out,
  output logic          sr_out
);
  logic [SW:0] sum;

  assign sum = {1'b0, a} + {1'b0, b} + {{SW{1'b0}}, cin};

  always_comb begin
    case (fn)
      F_SUM:   r = sum[SW-1:0];
      F_AND:   r = a & b;
      F_OR:    r = a | b;
      F_XOR:   r = a ^ b;
      F_NOTA:  r = ~a;
      F_PASSB: r = b;
      F_SHL:   r = {a[SW-2:0], sl_in};
      F_SHR:   r = {sr_in, a[SW-1:1]};
      default: r = a;
    endcase
  end

  assign cout   = (fn == F_SUM) && sum[SW];
  assign zero   = ~|r;
  assign sl_out = a[SW-1];
  assign sr_out = a[0];

  generate
    if (IS_MSB) begin : g_top
      assign ovf = (fn == F_SUM) && (a[SW-1] == b[SW-1]) && (sum[SW-1] != a[SW-1]);
    end else begin : g_low
      assign ovf = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/duo_alu_flags.sv
`timescale 1ns/1ps
module duo_alu_flags
  import duo_alu_pkg::*;
#(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  flags_t        nxt,
  output logic [FW-1:0] bus
);
  localparam int PAD = FW - $bits(flags_t);

  flags_t q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (upd) q <= nxt;
  end

  assign bus = {{PAD{1'b0}}, q};
endmodule

// File: rtl/duo_alu.sv
`timescale 1ns/1ps
module duo_alu
  import duo_alu_pkg::*;
#(
  parameter int SLICE_W = 4,
  parameter int SLICES  = 2,
  parameter int FLAG_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alu_valid,
  input  logic [3:0]                 alu_op,
  input  logic [SLICE_W*SLICES-1:0]  d_in,
  input  logic                       flag_clr,
  output logic [SLICE_W*SLICES-1:0]  acc_out,
  output logic [FLAG_W-1:0]          flags_out
);
  localparam int W = SLICE_W * SLICES;

  logic [W-1:0] acc_q;
  logic [W-1:0] opa;
  logic [W-1:0] opb;
  logic [W-1:0] result;
  slice_fn_e    fn;
  logic         lsb_in;
  logic         msb_in;
  logic         wr_acc;
  logic         upd_flags;

  logic [SLICES:0]   carry_ch;
  logic [SLICES:0]   sl_ch;
  logic [SLICES:0]   sr_ch;
  logic [SLICES-1:0] zero_w;
  logic [SLICES-1:0] ovf_w;
  flags_t            nxt_flags;
  logic              carry_flag;

  duo_alu_decode #(.W(W)) u_dec (
    .op        (alu_op),
    .acc       (acc_q),
    .d         (d_in),
    .opa       (opa),
    .opb       (opb),
    .fn        (fn),
    .lsb_in    (lsb_in),
    .msb_in    (msb_in),
    .wr_acc    (wr_acc),
    .upd_flags (upd_flags)
  );

  assign carry_ch[0]    = 1'b0;
  assign sl_ch[0]       = lsb_in;
  assign sr_ch[SLICES]  = msb_in;

  generate
    for (genvar i = 0; i < SLICES; i++) begin : g_slice
      duo_alu_slice #(
        .SW     (SLICE_W),
        .IS_MSB (i == SLICES - 1)
      ) u_slice (
        .fn     (fn),
        .a      (opa[i*SLICE_W +: SLICE_W]),
        .b      (opb[i*SLICE_W +: SLICE_W]),
        .cin    (carry_ch[i]),
        .sl_in  (sl_ch[i]),
        .sr_in  (sr_ch[i+1]),
        .r      (result[i*SLICE_W +: SLICE_W]),
        .cout   (carry_ch[i+1]),
        .zero   (zero_w[i]),
        .ovf    (ovf_w[i]),
        .sl_out (sl_ch[i+1]),
        .sr_out (sr_ch[i])
      );
    end
  endgenerate

  always_comb begin
    case (fn)
      F_SUM:   carry_flag = carry_ch[SLICES];
      F_SHL:   carry_flag = sl_ch[SLICES];
      F_SHR:   carry_flag = sr_ch[0];
      default: carry_flag = 1'b0;
    endcase
  end

  assign nxt_flags.c = carry_flag;
  assign nxt_flags.z = &zero_w;
  assign nxt_flags.n = result[W-1];
  assign nxt_flags.v = |ovf_w;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)                 acc_q <= '0;
    else if (alu_valid && wr_acc) acc_q <= result;
  end

  duo_alu_flags #(.FW(FLAG_W)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (flag_clr),
    .upd   (alu_valid && upd_flags),
    .nxt   (nxt_flags),
    .bus   (flags_out)
  );

  assign acc_out = acc_q;
endmodule

// File: rtl/duo_alu_chk.sv
`timescale 1ns/1ps
module duo_alu_chk #(
  parameter int W      = 8,
  parameter int FLAG_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alu_valid,
  input logic [3:0]        alu_op,
  input logic [W-1:0]      d_in,
  input logic              flag_clr,
  input logic [W-1:0]      acc_out,
  input logic [FLAG_W-1:0] flags_out
);
  logic flag_op;
  logic logic_op;
  logic rot_op;

  assign flag_op  = alu_valid && (alu_op < 4'd13) && !flag_clr;
  assign rot_op   = alu_valid && (alu_op == 4'd13 || alu_op == 4'd14) && !flag_clr;
  assign logic_op = alu_valid && !flag_clr &&
                    ((alu_op >= 4'd6 && alu_op <= 4'd9) || alu_op == 4'd12);

  a_r10_idle_hold: assert property (@(negedge clk) disable iff (!rst_n)
    (!alu_valid && !flag_clr) |=> ($stable(acc_out) && $stable(flags_out)));

  a_r9_clear: assert property (@(negedge clk) disable iff (!rst_n)
    flag_clr |=> (flags_out == '0));

  a_r7_rot_keeps_flags: assert property (@(negedge clk) disable iff (!rst_n)
    rot_op |=> $stable(flags_out));

  a_r8_zero: assert property (@(negedge clk) disable iff (!rst_n)
    flag_op |=> (flags_out[1] == (acc_out == '0)));

  a_r8_negative: assert property (@(negedge clk) disable iff (!rst_n)
    flag_op |=> (flags_out[2] == acc_out[W-1]));

  a_r6_shift_left: assert property (@(negedge clk) disable iff (!rst_n)
    (alu_valid && alu_op == 4'd10) |=> (acc_out == {$past(acc_out[W-2:0]), 1'b0}));

  a_r5_logic_cv: assert property (@(negedge clk) disable iff (!rst_n)
    logic_op |=> (flags_out[0] == 1'b0 && flags_out[3] == 1'b0));

  a_r3_no_overflow: assert property (@(negedge clk) disable iff (!rst_n)
    (alu_valid && !flag_clr && alu_op == 4'd0 && (acc_out[W-1] != d_in[W-1]))
      |=> (flags_out[3] == 1'b0));
endmodule

bind duo_alu duo_alu_chk #(.W(SLICE_W*SLICES), .FLAG_W(FLAG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .alu_valid (alu_valid),
  .alu_op    (alu_op),
  .d_in      (d_in),
  .flag_clr  (flag_clr),
  .acc_out   (acc_out),
  .flags_out (flags_out)
);

// File: tb/sim_duo_alu.sv
`timescale 1ns/1ps
module sim_duo_alu;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       alu_valid;
  logic [3:0] alu_op;
  logic [7:0] d_in;
  logic       flag_clr;
  logic [7:0] acc_out;
  logic [7:0] flags_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [7:0] m_acc;
  logic [3:0] m_flg;

  always #2.5 clk = ~clk;

  duo_alu u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .alu_valid (alu_valid),
    .alu_op    (alu_op),
    .d_in      (d_in),
    .flag_clr  (flag_clr),
    .acc_out   (acc_out),
    .flags_out (flags_out)
  );

  // returns {new flags {v,n,z,c}, new acc}
  function automatic logic [11:0] model(input logic [3:0] op, input logic [7:0] a,
                                        input logic [7:0] d, input logic [3:0] fl);
    logic [8:0] s;
    logic [7:0] x, y, r;
    logic c, v, upd;
    x = 8'h00; y = 8'h00; r = a; c = 1'b0; v = 1'b0; upd = 1'b1;
    case (op)
      4'd0: begin x = a; y = d; end
      4'd1: begin x = a; y = 8'h01; end
      4'd2: begin x = a; y = 8'h00 - d; end
      4'd3: begin x = d; y = 8'h00 - a; end
      4'd4: begin x = 8'h00; y = 8'h00 - a; end
      4'd5: begin x = a; y = 8'hFF; end
      default: ;
    endcase
    if (op <= 4'd5) begin
      s = {1'b0, x} + {1'b0, y};
      r = s[7:0];
      c = s[8];
      v = (x[7] == y[7]) && (r[7] != x[7]);
    end
    case (op)
      4'd6:  r = a & d;
      4'd7:  r = a | d;
      4'd8:  r = a ^ d;
      4'd9:  r = ~a;
      4'd10: begin r = {a[6:0], 1'b0}; c = a[7]; end
      4'd11: begin r = {1'b0, a[7:1]}; c = a[0]; end
      4'd12: r = d;
      4'd13: begin r = {a[6:0], a[7]}; upd = 1'b0; end
      4'd14: begin r = {a[0], a[7:1]}; upd = 1'b0; end
      4'd15: begin r = a; upd = 1'b0; end
      default: ;
    endcase
    model = upd ? {v, r[7], (r == 8'h00), c, r} : {fl, r};
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    if (op <= 4'd1) return "R2";
    if (op <= 4'd5) return "R4";
    if (op <= 4'd9 || op == 4'd12) return "R5";
    if (op <= 4'd11) return "R6";
    if (op <= 4'd14) return "R7";
    return "R10";
  endfunction

  task automatic check(input string tag, input logic [7:0] exp_acc, input logic [7:0] exp_flg);
    n_chk++;
    if (acc_out !== exp_acc || flags_out !== exp_flg) begin
      n_fail++;
      $display("FAIL %s: acc=%02h flags=%02h expected acc=%02h flags=%02h",
               tag, acc_out, flags_out, exp_acc, exp_flg);
    end
  endtask

  // present one cycle of stimulus, then check one falling edge later
  task automatic step(input logic [3:0] op, input logic [7:0] d, input logic v,
                      input logic clr, input string tag);
    logic [11:0] m;
    @(posedge clk);
    #1;
    alu_op = op; d_in = d; alu_valid = v; flag_clr = clr;
    @(negedge clk);
    #1;
    if (v) begin
      m = model(op, m_acc, d, m_flg);
      m_acc = m[7:0];
      m_flg = m[11:8];
    end
    if (clr) m_flg = 4'h0;
    check(tag, m_acc, {4'h0, m_flg});
    alu_valid = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic load(input logic [7:0] v);
    step(4'd12, v, 1'b1, 1'b0, "R5");
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 1'b0; alu_valid = 1'b0; alu_op = 4'd0; d_in = 8'h00; flag_clr = 1'b0;
    m_acc = 8'h00; m_flg = 4'h0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", 8'h00, 8'h00);
    rst_n = 1'b1;

    // R3: carry chain and overflow only from the top slice
    load(8'h0F);
    step(4'd0, 8'h01, 1'b1, 1'b0, "R3");
    check("R3", 8'h10, 8'h00);
    load(8'h08);
    step(4'd0, 8'h08, 1'b1, 1'b0, "R3");
    check("R3", 8'h10, 8'h00);
    load(8'h7F);
    step(4'd0, 8'h01, 1'b1, 1'b0, "R3");
    check("R3", 8'h80, 8'h0C);

    // R4: subtract variants
    load(8'h05);
    step(4'd2, 8'h05, 1'b1, 1'b0, "R4");
    check("R4", 8'h00, 8'h03);
    load(8'h00);
    step(4'd4, 8'h33, 1'b1, 1'b0, "R4");
    check("R4", 8'h00, 8'h02);
    load(8'h03);
    step(4'd3, 8'h10, 1'b1, 1'b0, "R4");
    load(8'h00);
    step(4'd5, 8'h00, 1'b1, 1'b0, "R4");
    check("R4", 8'hFF, 8'h04);

    // R8: zero needs both nibbles zero
    load(8'hF0);
    step(4'd6, 8'h0F, 1'b1, 1'b0, "R8");
    check("R8", 8'h00, 8'h02);
    load(8'h10);
    step(4'd6, 8'h10, 1'b1, 1'b0, "R8");
    check("R8", 8'h10, 8'h00);

    // R6: shifts report the bit shifted out
    load(8'h81);
    step(4'd10, 8'h00, 1'b1, 1'b0, "R6");
    check("R6", 8'h02, 8'h01);
    load(8'h81);
    step(4'd11, 8'h00, 1'b1, 1'b0, "R6");
    check("R6", 8'h40, 8'h01);

    // R7: rotation keeps flags set by previous op
    step(4'd14, 8'h00, 1'b1, 1'b0, "R7");
    check("R7", 8'h20, 8'h01);
    step(4'd13, 8'h00, 1'b1, 1'b0, "R7");
    check("R7", 8'h40, 8'h01);

    // R9: clear wins over a simultaneous flag update
    load(8'h80);
    step(4'd10, 8'h00, 1'b1, 1'b1, "R9");
    check("R9", 8'h00, 8'h00);

    // R10: idle and reserved code change nothing
    load(8'h7F);
    step(4'd0, 8'h01, 1'b1, 1'b0, "R2");
    step(4'd12, 8'h55, 1'b0, 1'b0, "R10");
    check("R10", 8'h80, 8'h0C);
    step(4'd15, 8'h55, 1'b1, 1'b0, "R10");
    check("R10", 8'h80, 8'h0C);

    // R2: count-up ignores d_in
    load(8'hFF);
    step(4'd1, 8'h77, 1'b1, 1'b0, "R2");
    check("R2", 8'h00, 8'h03);

    // random mix
    for (int i = 0; i < 800; i++) begin
      logic [3:0] op;
      logic [7:0] d;
      logic v, c;
      op = 4'($urandom_range(0, 15));
      d  = 8'($urandom_range(0, 255));
      v  = ($urandom_range(0, 9) != 0);
      c  = ($urandom_range(0, 19) == 0);
      step(op, d, v, c, c ? "R9" : (v ? tag_of(op) : "R10"));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule